// File: doc/BRIEF.md
# Extended Latin-Square Check-Bit Encoder

This block computes the check bits for a 20-bit data word protected by a double-error-correcting code. The code is built on a 4x4 square of base data bits. It has four parity groups of four check rows each. In every group, each base bit feeds exactly one row. Any two data bits share at most one check row, so the matching decoder can correct each bit with a single majority vote.

Four extra data bits extend the square code. Each extra bit is folded into all four rows of its own group. The result is that 20 data bits are protected by 16 check bits.

The parity logic is a flat XOR per check row. Its inputs are selected by masks that are computed at elaboration time. One register stage sits at the output and is loaded whenever a valid word is presented. The result is a systematic 36-bit codeword: the data goes out unchanged in the low bits and the check bits are appended above it.

Top module: `olsx_encoder`

## Requirements
- R1: Group 0 check bit r (codeword bit 20+r, r=0..3) is the XOR of base data bits 4r..4r+3 and extension bit 16.
- R2: Group 1 check bit r (codeword bit 24+r) is the XOR of base data bits r, r+4, r+8, r+12 and extension bit 17.
- R3: Group 2 check bit r (codeword bit 28+r) is the XOR of the base data bits d=4i+j for which i XOR j equals r, together with extension bit 18.
- R4: Group 3 check bit r (codeword bit 32+r) is the XOR of the base data bits d=4i+j for which i XOR (2·j) equals r, together with extension bit 19. The product 2·j is taken in GF(4) with x²+x+1, so 1→2, 2→3, 3→1.
- R5: A word whose only set bit is extension bit 16+g sets all four check bits of group g and no other check bit.
- R6: Codeword bits 19:0 equal the accepted data word unchanged, and bits 35:20 hold the 16 check bits.
- R7: out_valid is high exactly in the cycle after a clock edge at which in_valid was high. The codeword for that input appears in that same cycle.
- R8: While rst is high at a clock edge, out_valid and out_codeword are cleared to zero at that edge.
- R9: A base data bit alone sets exactly four check bits, one in each group. Every valid codeword has an even number of ones among its check bits.
- R10: At an edge where in_valid is low, out_codeword keeps its value, whatever in_data holds.
- R11: Flip any one or two bits of a produced codeword. Majority decoding of the result, where a bit is flipped when at least three of its four check rows disagree, still returns the original data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The data word is to be encoded at this edge |
| in_data | input | 20 | Data word: bits 15:0 base square, bits 19:16 extension |
| out_valid | output | 1 | The codeword register holds a fresh word |
| out_codeword | output | 36 | {check[15:0], data[19:0]} |

## Verification
The bench sets in_data and in_valid at a falling edge. The next rising edge loads the single output register, so every codeword and its out_valid are due one rising edge later. The bench samples them at the following falling edge. Hold and valid-drop behaviour is checked at the falling edge after an edge with in_valid low. In that cycle in_data is deliberately changed, so that any wrongly loaded word would show. The reset state is read at a falling edge while rst is still high.

// File: rtl/olsx_pkg.sv
package olsx_pkg;

  localparam int unsigned SQ     = 4;            // order of the square
  localparam int unsigned T_CORR = 2;            // correctable errors
  localparam int unsigned N_GRP  = 2 * T_CORR;   // parity groups
  localparam int unsigned K_BASE = SQ * SQ;      // base data bits
  localparam int unsigned K_EXT  = N_GRP;        // one extension bit per group
  localparam int unsigned K_DATA = K_BASE + K_EXT;
  localparam int unsigned N_CHK  = N_GRP * SQ;
  localparam int unsigned N_CW   = K_DATA + N_CHK;

  // Product in GF(4), polynomial x^2 + x + 1
  function automatic logic [1:0] gf4_mul(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] acc;
    logic [1:0] sh;
    acc = 2'b00;
    sh  = a;
    for (int k = 0; k < 2; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = {sh[1] ^ sh[0], sh[1]};
    end
    return acc;
  endfunction

  // Row of group g that base data bit d feeds
  function automatic logic [1:0] grp_row(input int g, input int d);
    logic [1:0] ri;
    logic [1:0] cj;
    ri = 2'(d / SQ);
    cj = 2'(d % SQ);
    case (g)
      0:       return ri;
      1:       return cj;
      2:       return ri ^ cj;
      default: return ri ^ gf4_mul(2'd2, cj);
    endcase
  endfunction

  // Data positions covered by row r of group g
  function automatic logic [K_DATA-1:0] row_mask(input int g, input int r);
    logic [K_DATA-1:0] m;
    m = '0;
    for (int d = 0; d < K_BASE; d++) begin
      if (int'(grp_row(g, d)) == r) m[d] = 1'b1;
    end
    m[K_BASE + g] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/olsx_group_xor.sv
module olsx_group_xor #(
  parameter int unsigned GRP  = 0,
  parameter int unsigned DW   = olsx_pkg::K_DATA,
  parameter int unsigned ROWS = olsx_pkg::SQ
) (
  input  logic [DW-1:0]   data_i,
  output logic [ROWS-1:0] chk_o
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam logic [DW-1:0] MASK = DW'(olsx_pkg::row_mask(GRP, r));
    assign chk_o[r] = ^(data_i & MASK);
  end

endmodule

// File: rtl/olsx_out_stage.sv
module olsx_out_stage #(
  parameter int unsigned W = olsx_pkg::N_CW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  input  logic [W-1:0] d_i,
  output logic         vld_o,
  output logic [W-1:0] d_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      d_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) d_o <= d_i;
    end
  end

endmodule

// File: rtl/olsx_encoder.sv
module olsx_encoder
  import olsx_pkg::*;
#(
  parameter int unsigned ROWS = SQ,
  parameter int unsigned GRPS = N_GRP,
  parameter int unsigned KB   = K_BASE,
  parameter int unsigned KD   = K_DATA,
  localparam int unsigned NC  = GRPS * ROWS,
  localparam int unsigned CW  = KD + NC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [KD-1:0] in_data,
  output logic          out_valid,
  output logic [CW-1:0] out_codeword
);

  logic [NC-1:0] chk;
  logic [CW-1:0] cw_next;

  for (genvar g = 0; g < GRPS; g++) begin : g_grp
    olsx_group_xor #(
      .GRP (g),
      .DW  (KD),
      .ROWS(ROWS)
    ) u_grp (
      .data_i(in_data),
      .chk_o (chk[g*ROWS +: ROWS])
    );
  end

  assign cw_next = {chk, in_data};

  olsx_out_stage #(.W(CW)) u_stage (
    .clk  (clk),
    .rst  (rst),
    .vld_i(in_valid),
    .d_i  (cw_next),
    .vld_o(out_valid),
    .d_o  (out_codeword)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_codeword == '0)); // R8

  AST_DATA_PASS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_codeword[KD-1:0] == $past(in_data)); // R6

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R7

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_codeword)); // R10

  AST_CHECK_EVEN: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (^out_codeword[CW-1:KD]) == 1'b0); // R9

  for (genvar g = 0; g < GRPS; g++) begin : g_bal
    AST_GROUP_BALANCE: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (^out_codeword[KD + g*ROWS +: ROWS]) == (^out_codeword[KB-1:0])); // R9
  end

endmodule

// File: tb/olsx_encoder_tb_top.sv
module olsx_encoder_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [19:0] in_data;
  logic        out_valid;
  logic [35:0] out_codeword;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  olsx_encoder dut_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .out_valid   (out_valid),
    .out_codeword(out_codeword)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] mul_alpha(input logic [1:0] v);
    return {v[1] ^ v[0], v[1]};
  endfunction

  function automatic logic [15:0] model_chk(input logic [19:0] d);
    logic [15:0] c;
    logic [1:0]  i;
    logic [1:0]  j;
    c = '0;
    for (int b = 0; b < 16; b++) begin
      i = 2'(b / 4);
      j = 2'(b % 4);
      if (d[b]) begin
        c[int'(i)]                       ^= 1'b1;
        c[4 + int'(j)]                   ^= 1'b1;
        c[8 + int'(i ^ j)]               ^= 1'b1;
        c[12 + int'(i ^ mul_alpha(j))]   ^= 1'b1;
      end
    end
    for (int g = 0; g < 4; g++)
      if (d[16+g]) c[g*4 +: 4] ^= 4'hF;
    return c;
  endfunction

  function automatic logic [19:0] decode(input logic [35:0] rx);
    logic [15:0] syn;
    logic [19:0] d;
    logic [1:0]  i;
    logic [1:0]  j;
    int          votes;
    d   = rx[19:0];
    syn = rx[35:20] ^ model_chk(rx[19:0]);
    for (int b = 0; b < 16; b++) begin
      i = 2'(b / 4);
      j = 2'(b % 4);
      votes = int'(syn[int'(i)]) + int'(syn[4 + int'(j)]) + int'(syn[8 + int'(i ^ j)])
            + int'(syn[12 + int'(i ^ mul_alpha(j))]);
      if (votes >= 3) d[b] = ~d[b];
    end
    for (int g = 0; g < 4; g++)
      if ($countones(syn[g*4 +: 4]) >= 3) d[16+g] = ~d[16+g];
    return d;
  endfunction

  // Present one word for one edge; returns at the falling edge after capture
  task automatic drive_one(input logic [19:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic compare_word(input logic [19:0] d);
    logic [15:0] e;
    e = model_chk(d);
    check("R7", "out_valid", 64'(out_valid), 64'd1);
    check("R1", "group0", 64'(out_codeword[23:20]), 64'(e[3:0]));
    check("R2", "group1", 64'(out_codeword[27:24]), 64'(e[7:4]));
    check("R3", "group2", 64'(out_codeword[31:28]), 64'(e[11:8]));
    check("R4", "group3", 64'(out_codeword[35:32]), 64'(e[15:12]));
    check("R6", "data field", 64'(out_codeword[19:0]), 64'(d));
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    check("R8", "out_valid in reset", 64'(out_valid), 64'd0);
    check("R8", "codeword in reset", 64'(out_codeword), 64'd0);
    in_valid = 1'b1; in_data = 20'hFFFFF;
    @(negedge clk);
    check("R8", "valid ignored in reset", 64'(out_valid), 64'd0);
    check("R8", "codeword held zero", 64'(out_codeword), 64'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_walk_base();
    for (int b = 0; b < 16; b++) begin
      drive_one(20'(1) << b);
      compare_word(20'(1) << b);
      check("R9", "check weight", 64'($countones(out_codeword[35:20])), 64'd4);
      for (int g = 0; g < 4; g++)
        check("R9", "one per group", 64'($countones(out_codeword[20 + g*4 +: 4])), 64'd1);
    end
  endtask

  task automatic t_walk_ext();
    for (int g = 0; g < 4; g++) begin
      drive_one(20'(1) << (16 + g));
      check("R5", "extension spread", 64'(out_codeword[35:20]), 64'(16'hF << (4*g)));
      check("R6", "extension data", 64'(out_codeword[19:0]), 64'(20'(1) << (16 + g)));
    end
  endtask

  task automatic t_patterns();
    logic [19:0] fixed [5] = '{20'h00000, 20'hFFFFF, 20'h55555, 20'hAAAAA, 20'h0F0F0};
    logic [19:0] d;
    for (int k = 0; k < 5; k++) begin
      drive_one(fixed[k]);
      compare_word(fixed[k]);
    end
    for (int k = 0; k < 40; k++) begin
      d = 20'($urandom);
      drive_one(d);
      compare_word(d);
      check("R9", "even check weight", 64'(^out_codeword[35:20]), 64'd0);
    end
  endtask

  task automatic t_stream();
    logic [19:0] a;
    logic [19:0] b;
    logic [19:0] c;
    logic [35:0] held;
    a = 20'h12345; b = 20'hABCDE; c = 20'h0BEEF;
    @(negedge clk);
    in_valid = 1'b1; in_data = a;
    @(negedge clk);
    compare_word(a);
    in_data = b;
    @(negedge clk);
    compare_word(b);
    in_valid = 1'b0; in_data = c;
    held = out_codeword;
    @(negedge clk);
    check("R7", "valid drop", 64'(out_valid), 64'd0);
    check("R10", "hold when idle", 64'(out_codeword), 64'(held));
    in_data = ~c;
    @(negedge clk);
    check("R10", "hold second idle", 64'(out_codeword), 64'(held));
  endtask

  task automatic t_roundtrip();
    logic [19:0] d;
    logic [35:0] rx;
    int p1;
    int p2;
    for (int k = 0; k < 40; k++) begin
      d = 20'($urandom);
      drive_one(d);
      rx = out_codeword;
      check("R11", "no error", 64'(decode(rx)), 64'(d));
      p1 = $urandom_range(35, 0);
      rx[p1] = ~rx[p1];
      if (k % 2 == 1) begin
        p2 = (p1 + 1 + $urandom_range(34, 0)) % 36;
        rx[p2] = ~rx[p2];
      end
      check("R11", "corrected", 64'(decode(rx)), 64'(d));
    end
  endtask

  initial begin
    t_reset();
    t_walk_base();
    t_walk_ext();
    t_patterns();
    t_stream();
    t_roundtrip();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000 - 80);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule